// File: doc/BRIEF.md
# GPIO external interrupt controller

This block watches one bank of 32 external pins and turns programmed pin events into a single interrupt request. Every line has its own four-bit trigger code that selects rising edge, falling edge, high level, low level or both edges. Pins pass through a two-stage synchronizer. Edges are found by comparing the synchronized sample with the sample from the cycle before. A detected event sets a sticky pending bit for that line.

Software reaches the block through a word-wide register port. That port has single-cycle writes and returns read data one cycle after the read strobe. Pending bits are cleared by writing ones to them. A registered interrupt output is high whenever some line is both pending and enabled. The parameter `BANK` places the bank's register group at `0x200 + BANK*0x20`, so several copies can share one address space.

Top module: `pin_irq_bank`

## Requirements
- R1: After reset, every trigger code, enable bit and pending bit is zero, and `irq_out` is low.
- R2: Line n's trigger code is held at bits `[(n%8)*4 +: 4]` of the configuration word at group offset `4*(n/8)` (offsets 0x00 to 0x0C). The code reads back as written.
- R3: The enable word sits at group offset 0x10, with line n at bit n. It reads back as written.
- R4: Code 0 sets line n's pending bit when the pin goes from 0 to 1. The bit sets at the third rising clock edge after the pin changes.
- R5: Code 1 sets the pending bit when the pin goes from 1 to 0. A 0-to-1 change has no effect.
- R6: Code 2 (high) and code 3 (low) set the pending bit on every cycle the synchronized pin holds that level. A clear issued while the level persists leaves the bit set.
- R7: Code 4 sets the pending bit on any change of the synchronized pin.
- R8: Codes 5 to 15 never set the pending bit.
- R9: The pending word sits at group offset 0x14, with line n at bit n. Writing 1 to a bit clears it, and writing 0 leaves it alone. An event in the same cycle as a clear takes priority and keeps the bit set.
- R10: Pending bits set whatever the enable bits hold. `irq_out` equals, one cycle later, the OR over all lines of (pending AND enabled).
- R11: A read of any address outside the group, or of an address with nonzero low two bits, returns zero. A write to such an address changes nothing.
- R12: `bus_rdata` carries the addressed word from the clock edge that samples `bus_rd`. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | LINES | Asynchronous external pin levels |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The assertions check four things on every cycle:
- a detected event always leaves its pending bit set on the next edge, even against a clear;
- a reserved code never raises a clear pending bit;
- a write of ones clears every bit that had no event;
- `irq_out`, unmapped reads and idle read data follow R10 to R12.

The bench scenarios show the rest: each trigger code responding to real pin waveforms through the synchronizer, the register layout including the bank displacement, level re-setting after a clear, and the gating of the interrupt by the enable word.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int CFG_BITS     = 4;
    localparam int GROUP_BASE   = 'h200;
    localparam int GROUP_STRIDE = 'h20;
    localparam int OFS_CFG      = 'h00;
    localparam int OFS_EN       = 'h10;
    localparam int OFS_PEND     = 'h14;

    typedef enum logic [CFG_BITS-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/irq_line_detect.sv
module irq_line_detect
    import pin_irq_pkg::*;
(
    input  logic [CFG_BITS-1:0] mode,
    input  logic                now_lvl,
    input  logic                prev_lvl,
    output logic                hit
);
    always_comb begin
        hit = 1'b0;
        case (mode)
            TRIG_RISE: hit = now_lvl & ~prev_lvl;
            TRIG_FALL: hit = ~now_lvl & prev_lvl;
            TRIG_HIGH: hit = now_lvl;
            TRIG_LOW:  hit = ~now_lvl;
            TRIG_BOTH: hit = now_lvl ^ prev_lvl;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import pin_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK   = 0,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    input  logic                       rd,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W-1:0]          hit,
    output logic [DATA_W*CFG_BITS-1:0] cfg_flat,
    output logic [DATA_W-1:0]          enable_q,
    output logic [DATA_W-1:0]          pend_q,
    output logic [DATA_W-1:0]          rdata
);
    localparam int CFG_WORDS = (DATA_W * CFG_BITS) / DATA_W;
    localparam int WA_W      = ADDR_W - 2;
    localparam int BASE      = GROUP_BASE + BANK * GROUP_STRIDE;
    localparam logic [WA_W-1:0] EN_WA   = WA_W'((BASE + OFS_EN) >> 2);
    localparam logic [WA_W-1:0] PEND_WA = WA_W'((BASE + OFS_PEND) >> 2);

    logic [WA_W-1:0]                  wa;
    logic                             aligned;
    logic [CFG_WORDS-1:0]             cfg_sel;
    logic                             en_sel;
    logic                             pend_sel;
    logic                             mapped;
    logic [CFG_WORDS-1:0][DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0]                clr;
    logic [DATA_W-1:0]                rd_mux;

    assign wa      = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
        localparam logic [WA_W-1:0] CW = WA_W'((BASE + OFS_CFG + 4 * w) >> 2);
        assign cfg_sel[w] = aligned && (wa == CW);
        assign cfg_flat[w*DATA_W +: DATA_W] = cfg_q[w];
    end

    assign en_sel   = aligned && (wa == EN_WA);
    assign pend_sel = aligned && (wa == PEND_WA);
    assign mapped   = (|cfg_sel) | en_sel | pend_sel;
    assign clr      = (wr && pend_sel) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            enable_q <= '0;
            pend_q   <= '0;
        end else begin
            for (int k = 0; k < CFG_WORDS; k++) begin
                if (wr && cfg_sel[k]) cfg_q[k] <= wdata;
            end
            if (wr && en_sel) enable_q <= wdata;
            pend_q <= (pend_q & ~clr) | hit;
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < CFG_WORDS; k++) begin
            if (cfg_sel[k]) rd_mux = cfg_q[k];
        end
        if (en_sel)   rd_mux = enable_q;
        if (pend_sel) rd_mux = pend_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pend_sel) |=> ((pend_q & $past(wdata & ~hit)) == '0));

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (rdata == '0));

    p_read_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/pin_irq_bank.sv
module pin_irq_bank
    import pin_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK   = 0,
    parameter int LINES  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);
    logic [LINES-1:0]          sync_q;
    logic [LINES-1:0]          prev_q;
    logic [LINES-1:0]          hit;
    logic [LINES*CFG_BITS-1:0] cfg_flat;
    logic [LINES-1:0]          enable_q;
    logic [LINES-1:0]          pend_q;

    irq_pin_sync #(.W(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    irq_reg_file #(.ADDR_W(ADDR_W), .BANK(BANK), .DATA_W(LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .hit      (hit),
        .cfg_flat (cfg_flat),
        .enable_q (enable_q),
        .pend_q   (pend_q),
        .rdata    (bus_rdata)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [CFG_BITS-1:0] mode;
        assign mode = cfg_flat[i*CFG_BITS +: CFG_BITS];

        irq_line_detect u_det (
            .mode     (mode),
            .now_lvl  (sync_q[i]),
            .prev_lvl (prev_q[i]),
            .hit      (hit[i])
        );

        p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> pend_q[i]);

        p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode > 4'd4) && !pend_q[i]) |=> !pend_q[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |(pend_q & enable_q);
    end

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(pend_q & enable_q)));
endmodule

// File: tb/pin_irq_bank_tb.sv
`timescale 1ns/1ps
module pin_irq_bank_tb;
    localparam int ADDR_W = 12;
    localparam int BANK   = 1;
    localparam int BASE   = 'h200 + BANK * 'h20;
    localparam int A_CFG0 = BASE + 'h00;
    localparam int A_CFG1 = BASE + 'h04;
    localparam int A_CFG3 = BASE + 'h0C;
    localparam int A_EN   = BASE + 'h10;
    localparam int A_PEND = BASE + 'h14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       pin_in = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_out;

    int n_run  = 0;
    int n_fail = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    pin_irq_bank #(.ADDR_W(ADDR_W), .BANK(BANK), .LINES(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic report(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: read data checked at the falling edge after the sampling edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            report(bus_rdata === e, t, bus_rdata, e);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        @(posedge clk); #2;
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_addr = ADDR_W'(a); bus_rd = 1'b1;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic pins(input logic [31:0] v);
        @(posedge clk); #2;
        pin_in = v;
        idle(5);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        idle(3);
        @(negedge clk);
        report(irq_out === e, tag, 32'(irq_out), 32'(e));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got 0x00000000 expected 0x00000001");
        finish_run();
    end

    initial begin
        idle(4);
        @(posedge clk); #2 rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        report(irq_out === 1'b0, "R1 irq after reset", 32'(irq_out), 0);
        rd(A_CFG0, 32'h0, "R1 cfg0 reset");
        rd(A_EN,   32'h0, "R1 enable reset");
        rd(A_PEND, 32'h0, "R1 pending reset");

        // lines 0..7: rise, fall, high, low, both, rsv5, rsv15, rise
        wr(A_CFG0, 32'h0F54_3210);
        wr(A_CFG1, 32'h1111_1111);
        wr(A_CFG3, 32'hA5A5_A5A5);
        rd(A_CFG0, 32'h0F54_3210, "R2 cfg word0 readback");
        rd(A_CFG1, 32'h1111_1111, "R2 cfg word1 readback");
        rd(A_CFG3, 32'hA5A5_A5A5, "R2 cfg word3 readback");
        wr(A_CFG3, 32'h0);
        idle(4);
        rd(A_PEND, 32'h0000_0008, "R6 low level with pin at 0");
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, 32'h0000_0008, "R6 low level re-sets after clear");
        pins(32'h0000_0008);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, 32'h0, "R6 cleared once level gone");

        pins(32'h0000_007D);
        rd(A_PEND, 32'h0000_0015, "R4 R6 R7 R8 rise/high/both set, reserved quiet");
        chk_irq(1'b0, "R10 pending but disabled");
        wr(A_EN, 32'h0000_0004);
        rd(A_EN, 32'h0000_0004, "R3 enable readback");
        chk_irq(1'b1, "R10 enabled pending line");

        wr(A_PEND, 32'h0);
        rd(A_PEND, 32'h0000_0015, "R9 write 0 keeps pending");
        wr(A_PEND, 32'h0000_0001);
        rd(A_PEND, 32'h0000_0014, "R9 write 1 clears edge bit");
        wr(A_PEND, 32'h0000_0010);
        rd(A_PEND, 32'h0000_0004, "R9 clear both-edge bit");
        wr(A_PEND, 32'h0000_0004);
        rd(A_PEND, 32'h0000_0004, "R6 R9 high level wins over clear");
        pins(32'h0000_0079);
        wr(A_PEND, 32'h0000_0004);
        rd(A_PEND, 32'h0, "R9 clear after level drops");
        chk_irq(1'b0, "R10 irq drops with pending");

        pins(32'h0000_007B);
        rd(A_PEND, 32'h0, "R5 rise ignored by falling line");
        pins(32'h0000_0069);
        rd(A_PEND, 32'h0000_0012, "R5 R7 falling and both-edge set");

        wr(A_PEND, 32'hFFFF_FFFF);
        wr(BASE + 'h18, 32'hFFFF_FFFF);
        wr(A_EN + 1, 32'hFFFF_FFFF);
        rd(BASE + 'h18, 32'h0, "R11 unmapped offset reads zero");
        rd('h200, 32'h0, "R11 other bank group reads zero");
        rd(A_EN + 1, 32'h0, "R11 unaligned reads zero");
        rd(A_EN, 32'h0000_0004, "R11 unmapped writes ignored");

        pins(32'h8000_0069);
        rd(A_PEND, 32'h8000_0000, "R4 line 31 rise");
        wr(A_EN, 32'h8000_0000);
        chk_irq(1'b1, "R10 line 31 enabled");

        // R12: data holds while no read is issued
        idle(3);
        @(negedge clk);
        report(bus_rdata === 32'h8000_0000, "R12 rdata holds", bus_rdata, 32'h8000_0000);

        idle(4);
        if (exp_q.size() != 0) report(1'b0, "scoreboard drained", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule